// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer with Chained Prescalers

This block is a register-mapped 32-bit up-counting timer. A small register port gives software access to a control word, a prescale word, a compare value and the live count. The counter steps on ticks from one of two sources. The first is the peripheral bus clock. The second is a slower oscillator reference. Both sources arrive as single-cycle enable strobes inside one clock domain.

The oscillator path first passes through its own 4-bit divider and then through the shared 12-bit divider. The bus path uses only the 12-bit divider. The counter can run free and wrap around, or it can return to zero after it matches the compare value.

A self-clearing software reset returns the timer to a known state before it is configured. Software writes the reset bit and then polls it until it reads back as 0.

Top module: `gp_timer`

## Requirements
- R1: After the hardware reset, control reads 0, prescale reads 0, compare reads 0xFFFFFFFF and the counter reads 0. A read from any offset other than 0x00 (control), 0x04 (prescale), 0x10 (compare) or 0x24 (counter) returns 0.
- R2: Writing 1 to control bit 15 starts a software reset. Bit 15 then reads as 1 for exactly 4 clock cycles and then clears by itself. Register writes made during those cycles do not persist.
- R3: The software reset clears the counter, the prescale register, both divider phases and every control bit other than bit 15. It also sets compare to 0xFFFFFFFF.
- R4: When source code 1 is in control bits 8:6, the counter counts bus ticks and ignores oscillator ticks. A code other than 1 or 5 counts nothing.
- R5: When source code 5 is selected, oscillator ticks are counted only while control bit 10 (oscillator enable) is 1. Bus ticks are never counted with code 5.
- R6: Each divider passes one tick out of every (value+1) input ticks. The main value is in prescale bits 11:0 and the oscillator value is in prescale bits 15:12. The oscillator path goes through its own divider first and then through the main divider.
- R7: Control bit 0 gates counting. While it is 0 the count holds its value. Setting it to 1 again resumes counting from the held value.
- R8: With control bit 9 at 0, a counted tick that arrives while the count equals compare sets the count to 0.
- R9: With control bit 9 at 1, the compare value is ignored, and the count increments modulo 2^32 (it wraps from 0xFFFFFFFF to 0).
- R10: Only control bits 0, 6 to 8, 9, 10 and 15 read back, and bit 15 reads back only while a software reset is in progress. Only prescale bits 15:0 read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Enable strobe from the peripheral bus clock |
| osc_tick | input | 1 | Enable strobe from the oscillator reference |
| reg_addr | input | 8 | Byte offset of the register to access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
The hardest state to reach from the ports is the chained oscillator division. The count only changes after the 4-bit divider and the 12-bit divider have both rolled over, and only with the right source code and the oscillator enable both present. The vector table reaches this state by issuing a software reset, programming both divider fields together and then feeding a known number of oscillator strobes. The expected count is the strobe total divided by both divider ratios, rounded down. Other vectors in the same table feed only the strobes that should be ignored. The compare-reload sequence is checked one tick at a time around the match. The wrap at 0xFFFFFFFF cannot be reached in a short run, so it is covered by the step property in the checker.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_PRE   = 8'h04;
   localparam logic [7:0] OFS_CMP   = 8'h10;
   localparam logic [7:0] OFS_COUNT = 8'h24;

   localparam int BIT_RUN   = 0;
   localparam int BIT_SRC_LO = 6;
   localparam int BIT_FREE  = 9;
   localparam int BIT_OSCEN = 10;
   localparam int BIT_SWRST = 15;

   localparam logic [2:0] SRC_BUS = 3'd1;
   localparam logic [2:0] SRC_OSC = 3'd5;

   typedef struct packed {
      logic       run;
      logic [2:0] src;
      logic       free;
      logic       osc_en;
   } ctrl_t;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_tick,
   input  logic [DIV_W-1:0] div,
   output logic             out_tick
);
   generate
      if (DIV_W < 1) begin : g_bad
         $error("gpt_prescaler: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] phase_q;
   logic             roll;

   assign roll     = (phase_q >= div);
   assign out_tick = in_tick && roll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (clr) begin
         phase_q <= '0;
      end else if (in_tick) begin
         phase_q <= roll ? '0 : phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             free,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (tick) begin
         if (!free && (count == cmp)) count <= '0;
         else                         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int MAIN_W     = 12,
   parameter int OSC_W      = 4,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output ctrl_t             ctrl,
   output logic [MAIN_W-1:0] main_div,
   output logic [OSC_W-1:0]  osc_div,
   output logic [CNT_W-1:0]  cmp,
   output logic              swr_busy,
   output logic              swr_start
);
   localparam int RC_W = $clog2(RST_CYCLES + 1);

   logic [RC_W-1:0] rcnt_q;

   assign swr_start = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[BIT_SWRST] && !swr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         main_div <= '0;
         osc_div  <= '0;
         cmp      <= '1;
         swr_busy <= 1'b0;
         rcnt_q   <= '0;
      end else if (swr_start || swr_busy) begin
         ctrl     <= '0;
         main_div <= '0;
         osc_div  <= '0;
         cmp      <= '1;
         if (swr_start) begin
            swr_busy <= 1'b1;
            rcnt_q   <= RC_W'(RST_CYCLES - 1);
         end else if (rcnt_q == '0) begin
            swr_busy <= 1'b0;
         end else begin
            rcnt_q <= rcnt_q - 1'b1;
         end
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_CTRL: begin
               ctrl.run    <= reg_wdata[BIT_RUN];
               ctrl.src    <= reg_wdata[BIT_SRC_LO +: 3];
               ctrl.free   <= reg_wdata[BIT_FREE];
               ctrl.osc_en <= reg_wdata[BIT_OSCEN];
            end
            OFS_PRE: begin
               main_div <= reg_wdata[MAIN_W-1:0];
               osc_div  <= reg_wdata[MAIN_W +: OSC_W];
            end
            OFS_CMP: cmp <= reg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gpt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int MAIN_W     = 12,
   parameter int OSC_W      = 4,
   parameter int RST_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_tick,
   input  logic        osc_tick,
   input  logic [7:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   localparam int PRE_W = MAIN_W + OSC_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("gp_timer: CNT_W must be 2..32");
      end
      if (PRE_W > 32) begin : g_bad_pre
         $error("gp_timer: prescale fields exceed 32 bits");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("gp_timer: RST_CYCLES must be at least 1");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [MAIN_W-1:0] main_div;
   logic [OSC_W-1:0]  osc_div;
   logic [CNT_W-1:0]  cmp;
   logic [CNT_W-1:0]  count;
   logic              swr_busy;
   logic              swr_start;
   logic              seq_clr;
   logic              bus_in, osc_in, osc_div_tick, main_in, cnt_tick;

   gpt_regs #(
      .CNT_W(CNT_W), .MAIN_W(MAIN_W), .OSC_W(OSC_W), .RST_CYCLES(RST_CYCLES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .ctrl(ctrl), .main_div(main_div), .osc_div(osc_div),
      .cmp(cmp), .swr_busy(swr_busy), .swr_start(swr_start)
   );

   assign seq_clr = swr_start || swr_busy;
   assign bus_in  = bus_tick && ctrl.run && (ctrl.src == SRC_BUS);
   assign osc_in  = osc_tick && ctrl.run && ctrl.osc_en && (ctrl.src == SRC_OSC);

   gpt_prescaler #(.DIV_W(OSC_W)) u_osc_pre (
      .clk(clk), .rst_n(rst_n), .clr(seq_clr), .in_tick(osc_in),
      .div(osc_div), .out_tick(osc_div_tick)
   );

   assign main_in = bus_in || osc_div_tick;

   gpt_prescaler #(.DIV_W(MAIN_W)) u_main_pre (
      .clk(clk), .rst_n(rst_n), .clr(seq_clr), .in_tick(main_in),
      .div(main_div), .out_tick(cnt_tick)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(seq_clr), .tick(cnt_tick),
      .free(ctrl.free), .cmp(cmp), .count(count)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL: begin
            reg_rdata[BIT_RUN]           = ctrl.run;
            reg_rdata[BIT_SRC_LO +: 3]   = ctrl.src;
            reg_rdata[BIT_FREE]          = ctrl.free;
            reg_rdata[BIT_OSCEN]         = ctrl.osc_en;
            reg_rdata[BIT_SWRST]         = swr_busy;
         end
         OFS_PRE:   reg_rdata[PRE_W-1:0] = {osc_div, main_div};
         OFS_CMP:   reg_rdata[CNT_W-1:0] = cmp;
         OFS_COUNT: reg_rdata[CNT_W-1:0] = count;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
   parameter int CNT_W      = 32,
   parameter int RST_CYCLES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             start,
   input logic             run,
   input logic             free,
   input logic [2:0]       src,
   input logic             tick,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] count
);
   logic [15:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   // R2: reset lasts exactly RST_CYCLES cycles
   a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == 16'(RST_CYCLES)));
   a_r2_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= 16'(RST_CYCLES));
   // R3: counter is zero after each reset cycle
   a_r3_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (count == '0));
   // R7: count holds while not running
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !busy && !start) |=> $stable(count));
   // R4: unused source codes produce no counted tick
   a_r4_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (src != 3'd1 && src != 3'd5) |-> !tick);
   // R8: compare reload
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !free && count == cmp && !busy && !start) |=> (count == '0));
   // R9: count only steps by one or returns to zero
   a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_gpt_chk (
   .clk(clk), .rst_n(rst_n), .busy(swr_busy), .start(swr_start),
   .run(ctrl.run), .free(ctrl.free), .src(ctrl.src), .tick(cnt_tick),
   .cmp(cmp), .count(count)
);

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_tick = 1'b0;
   logic        osc_tick = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   gp_timer u_gp_timer (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .osc_tick(osc_tick),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   localparam int NV = 10;
   localparam logic [31:0] V_CTRL [NV] = '{32'h241, 32'h241, 32'h741, 32'h741, 32'h341,
                                          32'h241, 32'h741, 32'h281, 32'h741, 32'h241};
   localparam logic [31:0] V_PRE  [NV] = '{32'h0, 32'h2, 32'h1000, 32'h1002, 32'h0,
                                          32'h0, 32'h0, 32'h0, 32'hF000, 32'hFFF};
   localparam int          V_NBUS [NV] = '{10, 10, 0, 0, 10, 0, 10, 10, 0, 10};
   localparam int          V_NOSC [NV] = '{0, 0, 10, 12, 10, 10, 0, 10, 32, 0};
   localparam logic [31:0] V_EXP  [NV] = '{32'd10, 32'd3, 32'd5, 32'd2, 32'd0,
                                          32'd0, 32'd0, 32'd0, 32'd2, 32'd0};

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic pulses(input int nb, input int no);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk); bus_tick = 1'b1;
         @(negedge clk); bus_tick = 1'b0;
      end
      for (int i = 0; i < no; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
      end
   endtask

   task automatic soft_reset(output int len);
      logic [31:0] v;
      wr(8'h00, 32'h8000);
      len = 0;
      rd(8'h00, v);
      while (v[15] && len < 100) begin
         len++;
         rd(8'h00, v);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int len;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); check("R1 ctrl", v, 32'h0);
      rd(8'h04, v); check("R1 prescale", v, 32'h0);
      rd(8'h10, v); check("R1 compare", v, 32'hFFFF_FFFF);
      rd(8'h24, v); check("R1 counter", v, 32'h0);
      rd(8'h08, v); check("R1 unused offset", v, 32'h0);

      // R10 read-back masks
      wr(8'h00, 32'hFFFF_7FFE); rd(8'h00, v); check("R10 ctrl mask", v, 32'h0000_07C0);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R10 prescale mask", v, 32'h0000_FFFF);

      // R3 soft reset clears programmed state
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h241);
      pulses(4, 0);
      wr(8'h10, 32'h7);
      wr(8'h04, 32'h5);
      soft_reset(len);
      check("R2 busy length", 32'(len), 32'd4);
      rd(8'h24, v); check("R3 counter cleared", v, 32'h0);
      rd(8'h10, v); check("R3 compare ones", v, 32'hFFFF_FFFF);
      rd(8'h04, v); check("R3 prescale cleared", v, 32'h0);
      rd(8'h00, v); check("R3 ctrl cleared", v, 32'h0);

      // R2 writes during reset do not persist
      wr(8'h00, 32'h8000);
      wr(8'h04, 32'h0123);
      wr(8'h00, 32'h0241);
      repeat (6) @(negedge clk);
      rd(8'h04, v); check("R2 write during reset", v, 32'h0);
      rd(8'h00, v); check("R2 ctrl write during reset", v, 32'h0);

      // R4 R5 R6 vector table
      for (int k = 0; k < NV; k++) begin
         soft_reset(len);
         wr(8'h04, V_PRE[k]);
         wr(8'h00, V_CTRL[k]);
         pulses(V_NBUS[k], V_NOSC[k]);
         rd(8'h24, v);
         check($sformatf("R4/R5/R6 vector %0d (R4 R5 R6)", k), v, V_EXP[k]);
      end

      // R7 hold and resume
      soft_reset(len);
      wr(8'h00, 32'h241);
      pulses(3, 0);
      wr(8'h00, 32'h240);
      pulses(5, 0);
      rd(8'h24, v); check("R7 hold while disabled", v, 32'd3);
      wr(8'h00, 32'h241);
      pulses(2, 0);
      rd(8'h24, v); check("R7 resume", v, 32'd5);

      // R8 compare reload
      soft_reset(len);
      wr(8'h10, 32'd3);
      wr(8'h00, 32'h041);
      pulses(3, 0); rd(8'h24, v); check("R8 at compare", v, 32'd3);
      pulses(1, 0); rd(8'h24, v); check("R8 reload to zero", v, 32'd0);
      pulses(1, 0); rd(8'h24, v); check("R8 after reload", v, 32'd1);

      // R9 free-running ignores compare
      soft_reset(len);
      wr(8'h10, 32'd3);
      wr(8'h00, 32'h241);
      pulses(6, 0); rd(8'h24, v); check("R9 compare ignored", v, 32'd6);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule